// File: doc/BRIEF.md
# Prioritised Interrupt Acceptance Controller

This block is the receiving side of a per-core interrupt controller. It keeps three 256-bit vectors: pending requests, vectors in service, and trigger mode. It also keeps an 8-bit task priority and a spurious-vector register. Trigger pulses add pending requests. A single interrupt line tells the core that a request is worth taking. The core acknowledges to fetch a vector and later signals end-of-interrupt to retire it.

Priorities are compared by class, meaning the upper four bits of a vector. The task priority class sets a floor that a pending vector must beat before the line is raised. The controller also derives a processor priority and an arbitration priority from its state, for neighbouring blocks to use. An acknowledge that finds nothing eligible returns the spurious vector.

The trigger input is a valid-qualified transfer with no ready signal: it never applies back-pressure, and every pulse is judged in the cycle it appears. All other pins are plain control and status.

Top module: `intr_accept_ctrl`

## Requirements
- R1: A trigger whose vector is below 0x10 leaves every pending bit unchanged and pulses `err_illegal_vec` in the following cycle.
- R2: A legal trigger whose pending bit is clear sets that pending bit and writes `trig_level` into the trigger-mode bit (1 = level, 0 = edge). A trigger for a vector already pending changes neither vector.
- R3: `intr` rises one cycle after the controller sees both of these at once: the highest pending vector is above the highest in-service vector (or nothing is in service), and the pending vector's class is above the task-priority class.
- R4: `ppr` equals the task priority when nothing is in service or when the task class is at least the top in-service class. Otherwise it equals the top in-service class with a zero low nibble.
- R5: An acknowledge applies only when the highest pending vector's class, with a zero low nibble, is above `ppr`. In that case the highest pending vector moves from pending to in-service, and `ack_valid` with `ack_vec` report it in the following cycle.
- R6: An acknowledge with nothing pending, or with an ineligible top vector, reports the spurious vector and changes no vector. Every acknowledge drops `intr` in the following cycle.
- R7: A spurious-register write stores bits 7:4 with the low nibble forced to 1111 (legacy mode, the default). It stores bit 8 as software enable and bit 9 as focus disable. Reset leaves the vector at 0xFF and both flags at 0.
- R8: Lowering the task priority so that a pending vector becomes eligible raises `intr`.
- R9: Let t, s and p be the task, top in-service and top pending classes, with 0 standing for an empty vector. `apr` equals the task priority when t >= p and t > s. Otherwise it equals max(t AND s, p) shifted left by 4.
- R10: End-of-interrupt clears the highest set in-service bit. With nothing in service it has no effect.
- R11: Once raised, `intr` stays high until an acknowledge, even if the task priority rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Trigger pulse, always accepted |
| trig_vec | input | 8 | Vector being triggered |
| trig_level | input | 1 | 1 = level-triggered, 0 = edge |
| ack | input | 1 | Core acknowledge pulse |
| eoi | input | 1 | End-of-interrupt pulse |
| tpr_wr | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | New task priority |
| svr_wr | input | 1 | Spurious register write strobe |
| svr_wdata | input | 10 | Bit 9 focus disable, bit 8 enable, bits 7:0 vector |
| intr | output | 1 | Interrupt line to the core |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_vec | output | 8 | Vector returned by acknowledge |
| err_illegal_vec | output | 1 | One-cycle pulse for a rejected vector |
| tpr | output | 8 | Current task priority |
| ppr | output | 8 | Processor priority |
| apr | output | 8 | Arbitration priority |
| spur_vec | output | 8 | Spurious vector |
| sw_enable | output | 1 | Software enable flag |
| focus_dis | output | 1 | Focus disable flag |
| irr | output | 256 | Pending request vector |
| isr | output | 256 | In-service vector |
| tmr | output | 256 | Trigger-mode vector |

## Verification
Directed sequences cover the following cases:
- an illegal vector;
- a duplicate trigger with a different level;
- a lower vector arriving while a higher one is in service;
- an acknowledge with nothing pending;
- a task-priority drop that releases a waiting vector;
- a task-priority rise while the line is already high.

Between them they separate the in-service comparison from the task-class gate, and the spurious path from the move path. A long seeded random mix of triggers across the whole vector range, acknowledges, end-of-interrupts and task-priority writes follows. It fills and drains the vectors so that both derived priorities are compared against a requirement-level model on every cycle, in many differing state combinations.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int VEC_W   = 8;
  localparam int CLS_LSB = 4;
  localparam int MIN_VEC = 16;
  typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/prio_enc.sv
module prio_enc #(
  parameter int N  = 256,
  parameter int LO = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  bits,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (i >= LO && bits[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/prio_calc.sv
module prio_calc #(
  parameter int VW = 8,
  parameter int CL = 4,
  localparam int CW = VW - CL
) (
  input  logic [VW-1:0] tpr,
  input  logic          isr_any,
  input  logic [VW-1:0] isr_idx,
  input  logic          irr_any,
  input  logic [VW-1:0] irr_idx,
  output logic [VW-1:0] ppr,
  output logic [VW-1:0] apr,
  output logic          elig
);
  logic [CW-1:0] t_cls, s_cls, p_cls, ts_cls, mx_cls;

  assign t_cls  = tpr[VW-1:CL];
  assign s_cls  = isr_any ? isr_idx[VW-1:CL] : '0;
  assign p_cls  = irr_any ? irr_idx[VW-1:CL] : '0;
  assign ts_cls = t_cls & s_cls;
  assign mx_cls = (ts_cls > p_cls) ? ts_cls : p_cls;

  always_comb begin
    if (!isr_any || t_cls >= s_cls) ppr = tpr;
    else                            ppr = {s_cls, {CL{1'b0}}};
    if (t_cls >= p_cls && t_cls > s_cls) apr = tpr;
    else                                 apr = {mx_cls, {CL{1'b0}}};
  end

  assign elig = irr_any && (!isr_any || irr_idx > isr_idx) && (p_cls > t_cls);
endmodule

// File: rtl/intr_accept_ctrl.sv
module intr_accept_ctrl
  import intr_pkg::*;
#(
  parameter int VW     = VEC_W,
  parameter int MINV   = MIN_VEC,
  parameter bit LEGACY = 1'b1,
  localparam int NV    = 1 << VW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_valid,
  input  logic [VW-1:0] trig_vec,
  input  logic          trig_level,
  input  logic          ack,
  input  logic          eoi,
  input  logic          tpr_wr,
  input  logic [VW-1:0] tpr_wdata,
  input  logic          svr_wr,
  input  logic [VW+1:0] svr_wdata,
  output logic          intr,
  output logic          ack_valid,
  output logic [VW-1:0] ack_vec,
  output logic          err_illegal_vec,
  output logic [VW-1:0] tpr,
  output logic [VW-1:0] ppr,
  output logic [VW-1:0] apr,
  output logic [VW-1:0] spur_vec,
  output logic          sw_enable,
  output logic          focus_dis,
  output logic [NV-1:0] irr,
  output logic [NV-1:0] isr,
  output logic [NV-1:0] tmr
);
  localparam logic [VW-1:0] SPUR_FORCE = LEGACY ? VW'(4'hF) : '0;

  logic [NV-1:0] irr_q, isr_q, tmr_q, irr_n, isr_n, tmr_n;
  logic [VW-1:0] tpr_q, spur_q;
  logic          en_q, fd_q, intr_q;
  logic          irr_any, isr_any, elig, trig_ok, ack_take;
  logic [VW-1:0] irr_idx, isr_idx;

  prio_enc #(.N(NV), .LO(MINV)) u_irr_enc (.bits(irr_q), .any(irr_any), .idx(irr_idx));
  prio_enc #(.N(NV), .LO(MINV)) u_isr_enc (.bits(isr_q), .any(isr_any), .idx(isr_idx));

  prio_calc #(.VW(VW), .CL(CLS_LSB)) u_calc (
    .tpr(tpr_q), .isr_any(isr_any), .isr_idx(isr_idx),
    .irr_any(irr_any), .irr_idx(irr_idx),
    .ppr(ppr), .apr(apr), .elig(elig)
  );

  assign trig_ok  = trig_valid && (trig_vec >= VW'(MINV)) && !irr_q[trig_vec];
  assign ack_take = ack && irr_any && ({irr_idx[VW-1:CLS_LSB], {CLS_LSB{1'b0}}} > ppr);

  always_comb begin
    irr_n = irr_q;
    isr_n = isr_q;
    tmr_n = tmr_q;
    if (trig_ok) begin
      irr_n[trig_vec] = 1'b1;
      tmr_n[trig_vec] = trig_level;
    end
    if (eoi && isr_any) isr_n[isr_idx] = 1'b0;
    if (ack_take) begin
      irr_n[irr_idx] = 1'b0;
      isr_n[irr_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q           <= '0;
      isr_q           <= '0;
      tmr_q           <= '0;
      tpr_q           <= '0;
      spur_q          <= '1;
      en_q            <= 1'b0;
      fd_q            <= 1'b0;
      intr_q          <= 1'b0;
      ack_valid       <= 1'b0;
      ack_vec         <= '0;
      err_illegal_vec <= 1'b0;
    end else begin
      irr_q <= irr_n;
      isr_q <= isr_n;
      tmr_q <= tmr_n;
      if (tpr_wr) tpr_q <= tpr_wdata;
      if (svr_wr) begin
        spur_q <= svr_wdata[VW-1:0] | SPUR_FORCE;
        en_q   <= svr_wdata[VW];
        fd_q   <= svr_wdata[VW+1];
      end
      if (ack)                intr_q <= 1'b0;
      else if (!intr_q && elig) intr_q <= 1'b1;
      ack_valid       <= ack;
      ack_vec         <= ack_take ? irr_idx : spur_q;
      err_illegal_vec <= trig_valid && (trig_vec < VW'(MINV));
    end
  end

  assign intr      = intr_q;
  assign tpr       = tpr_q;
  assign spur_vec  = spur_q;
  assign sw_enable = en_q;
  assign focus_dis = fd_q;
  assign irr       = irr_q;
  assign isr       = isr_q;
  assign tmr       = tmr_q;

  // R1
  illegal_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid && (trig_vec < VW'(MINV)) && !ack |=> err_illegal_vec && $stable(irr_q));
  // R3
  intr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr_q) |-> $past(elig));
  // R4
  ppr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ppr >= tpr_q);
  // R5
  ack_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take && !eoi |=> $countones(isr_q) == $past($countones(isr_q)) + 1);
  // R6
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !intr_q && ack_valid);
  // R10
  eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi && isr_any && !ack |=> $countones(isr_q) + 1 == $past($countones(isr_q)));
endmodule

// File: tb/sim_intr_accept_ctrl.sv
module sim_intr_accept_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int OP_IDLE = 0, OP_TRIG = 1, OP_ACK = 2, OP_EOI = 3, OP_TPR = 4, OP_SVR = 5;

  logic clk = 0, rst_n = 0;
  logic trig_valid = 0, trig_level = 0, ack = 0, eoi = 0, tpr_wr = 0, svr_wr = 0;
  logic [7:0] trig_vec = 0, tpr_wdata = 0;
  logic [9:0] svr_wdata = 0;
  logic intr, ack_valid, err_illegal_vec, sw_enable, focus_dis;
  logic [7:0] ack_vec, tpr, ppr, apr, spur_vec;
  logic [255:0] irr, isr, tmr;

  int total = 0, bad = 0;

  logic [255:0] m_irr = '0, m_isr = '0, m_tmr = '0;
  logic [7:0] m_tpr = 0, m_spur = 8'hFF, m_ackv = 0;
  logic m_en = 0, m_fd = 0, m_intr = 0, m_err = 0, m_ackval = 0, m_spurious = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_accept_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_vec(trig_vec),
    .trig_level(trig_level), .ack(ack), .eoi(eoi), .tpr_wr(tpr_wr),
    .tpr_wdata(tpr_wdata), .svr_wr(svr_wr), .svr_wdata(svr_wdata),
    .intr(intr), .ack_valid(ack_valid), .ack_vec(ack_vec),
    .err_illegal_vec(err_illegal_vec), .tpr(tpr), .ppr(ppr), .apr(apr),
    .spur_vec(spur_vec), .sw_enable(sw_enable), .focus_dis(focus_dis),
    .irr(irr), .isr(isr), .tmr(tmr)
  );

  function automatic int top_bit(input logic [255:0] v);
    for (int i = 255; i >= 16; i--) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [7:0] f_ppr();
    int s = top_bit(m_isr);
    if (s < 0 || m_tpr[7:4] >= s[7:4]) return m_tpr;
    return {s[7:4], 4'h0};
  endfunction

  function automatic logic [7:0] f_apr();
    int t = m_tpr[7:4];
    int s = top_bit(m_isr) < 0 ? 0 : top_bit(m_isr) >> 4;
    int p = top_bit(m_irr) < 0 ? 0 : top_bit(m_irr) >> 4;
    int m;
    if (t >= p && t > s) return m_tpr;
    m = ((t & s) > p) ? (t & s) : p;
    return 8'(m << 4);
  endfunction

  function automatic bit f_elig();
    int p = top_bit(m_irr);
    int s = top_bit(m_isr);
    return p >= 0 && (s < 0 || p > s) && (p >> 4) > m_tpr[7:4];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string itag);
    chk(irr === m_irr, "R2 irr", irr, m_irr);
    chk(tmr === m_tmr, "R2 tmr", tmr, m_tmr);
    chk(isr === m_isr, "R10 isr", isr, m_isr);
    chk(intr === m_intr, itag, 256'(intr), 256'(m_intr));
    chk(ppr === f_ppr(), "R4 ppr", 256'(ppr), 256'(f_ppr()));
    chk(apr === f_apr(), "R9 apr", 256'(apr), 256'(f_apr()));
    chk(err_illegal_vec === m_err, "R1 err", 256'(err_illegal_vec), 256'(m_err));
    chk({focus_dis, sw_enable, spur_vec} === {m_fd, m_en, m_spur}, "R7 svr",
        256'({focus_dis, sw_enable, spur_vec}), 256'({m_fd, m_en, m_spur}));
    if (m_ackval)
      chk(ack_valid === 1'b1 && ack_vec === m_ackv, m_spurious ? "R6 ack" : "R5 ack",
          256'(ack_vec), 256'(m_ackv));
  endtask

  // Called at a negedge: drive one operation, model the edge, check at next negedge.
  task automatic step(input int op, input logic [7:0] v, input logic lvl,
                      input logic [9:0] d, input string itag);
    bit e_pre; int p;
    trig_valid = (op == OP_TRIG); trig_vec = v; trig_level = lvl;
    ack = (op == OP_ACK); eoi = (op == OP_EOI);
    tpr_wr = (op == OP_TPR); tpr_wdata = d[7:0];
    svr_wr = (op == OP_SVR); svr_wdata = d;
    @(posedge clk);
    e_pre = f_elig();
    m_err = (op == OP_TRIG) && (v < 8'h10);
    m_ackval = (op == OP_ACK);
    if (op == OP_ACK) begin
      p = top_bit(m_irr);
      m_spurious = !(p >= 0 && {p[7:4], 4'h0} > f_ppr());
      m_ackv = m_spurious ? m_spur : p[7:0];
      if (!m_spurious) begin m_irr[p] = 0; m_isr[p] = 1; end
      m_intr = 0;
    end else if (!m_intr && e_pre) m_intr = 1;
    if (op == OP_TRIG && v >= 8'h10 && !m_irr[v]) begin m_irr[v] = 1; m_tmr[v] = lvl; end
    if (op == OP_EOI && top_bit(m_isr) >= 0) m_isr[top_bit(m_isr)] = 0;
    if (op == OP_TPR) m_tpr = d[7:0];
    if (op == OP_SVR) begin m_spur = {d[7:4], 4'hF}; m_en = d[8]; m_fd = d[9]; end
    @(negedge clk);
    trig_valid = 0; ack = 0; eoi = 0; tpr_wr = 0; svr_wr = 0;
    check_all(itag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state: R7 spurious 0xFF, flags 0; nothing pending
    check_all("R3 reset intr");
    chk(spur_vec === 8'hFF, "R7 reset", 256'(spur_vec), 256'hFF);

    step(OP_TRIG, 8'h05, 1, 0, "R3");          // R1 illegal vector dropped
    step(OP_TRIG, 8'h40, 1, 0, "R3");          // R2 level bit recorded
    step(OP_IDLE, 0, 0, 0, "R3");              // R3 line rises
    chk(intr === 1'b1, "R3 rise", 256'(intr), 256'd1);
    step(OP_TRIG, 8'h40, 0, 0, "R3");          // R2 duplicate dropped, tmr stays 1
    chk(tmr[8'h40] === 1'b1, "R2 dup", 256'(tmr[8'h40]), 256'd1);
    step(OP_ACK, 0, 0, 0, "R6");               // R5 returns 0x40
    chk(ack_vec === 8'h40, "R5 vec", 256'(ack_vec), 256'h40);
    step(OP_TRIG, 8'h35, 0, 0, "R3");          // below in-service
    step(OP_IDLE, 0, 0, 0, "R3");
    chk(intr === 1'b0, "R3 blocked", 256'(intr), 256'd0);
    step(OP_EOI, 0, 0, 0, "R3");               // R10 clears 0x40
    step(OP_IDLE, 0, 0, 0, "R3");
    chk(intr === 1'b1, "R10 release", 256'(intr), 256'd1);
    step(OP_ACK, 0, 0, 0, "R6");
    step(OP_EOI, 0, 0, 0, "R3");
    step(OP_ACK, 0, 0, 0, "R6");               // R6 nothing pending
    chk(ack_vec === 8'hFF, "R6 spurious", 256'(ack_vec), 256'hFF);
    step(OP_SVR, 0, 0, 10'h3A5, "R3");         // R7 low nibble forced
    chk(spur_vec === 8'hAF, "R7 write", 256'(spur_vec), 256'hAF);
    step(OP_TPR, 0, 0, 10'h070, "R3");
    step(OP_TRIG, 8'h65, 0, 0, "R3");
    step(OP_IDLE, 0, 0, 0, "R3");
    chk(intr === 1'b0, "R3 tpr gate", 256'(intr), 256'd0);
    step(OP_TPR, 0, 0, 10'h020, "R8");         // R8 lowering releases
    step(OP_IDLE, 0, 0, 0, "R8");
    chk(intr === 1'b1, "R8 lower", 256'(intr), 256'd1);
    step(OP_TPR, 0, 0, 10'h0F0, "R11");        // R11 raise keeps line
    step(OP_IDLE, 0, 0, 0, "R11");
    chk(intr === 1'b1, "R11 hold", 256'(intr), 256'd1);
    step(OP_ACK, 0, 0, 0, "R6");               // ineligible: spurious 0xAF
    chk(ack_vec === 8'hAF, "R6 ineligible", 256'(ack_vec), 256'hAF);
    step(OP_TPR, 0, 0, 10'h000, "R8");

    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      logic [7:0] v = 8'($urandom_range(0, 255));
      if (r < 45)      step(OP_TRIG, v, 1'($urandom_range(0, 1)), 0, "R3");
      else if (r < 65) step(OP_ACK, 0, 0, 0, "R6");
      else if (r < 80) step(OP_EOI, 0, 0, 0, "R3");
      else if (r < 88) step(OP_TPR, 0, 0, {2'b00, v}, "R8");
      else if (r < 90) step(OP_SVR, 0, 0, 10'($urandom_range(0, 1023)), "R3");
      else             step(OP_IDLE, 0, 0, 0, "R3");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule